// File: doc/BRIEF.md
# Processor Bus Cycle Decoder

This block watches the cycle-definition lines of a 64-bit processor bus and turns them into one strobe per cycle type for the rest of the system board. The strobes cover interrupt acknowledge, special cycle, I/O read, I/O write, code fetch, memory read and memory write. A separate flag marks the one encoding that the processor never drives. A further output tells downstream logic whether the cycle moves a single beat of up to 64 bits or runs as a four-beat, 256-bit burst, which is either a cache line fill or a writeback.

The definition lines are only meaningful in the clock where the active-low address strobe is low. The block captures them in that clock and holds the decoded result until the downstream ready logic pulses a cycle-done input. The block then returns to idle. Address decoding, chip selects and ready generation belong to other blocks.

Top module: `bus_cycle_decoder`

## Requirements
- R1: While rst_ni is low, and in the first clock after it rises, every strobe, invalid_o and burst_o are 0.
- R2: The definition inputs are captured only at a rising clock edge where ads_ni is 0. Outputs show the capture from that edge onward. Changes on mio_i, dc_i, wr_i, cache_ni and ken_ni while ads_ni is 1 have no effect on any output.
- R3: The captured code {mio_i, dc_i, wr_i} maps to one strobe as follows. 000 drives inta_o. 001 drives special_o. 010 drives io_rd_o. 011 drives io_wr_o. 100 drives fetch_o. 110 drives mem_rd_o. 111 drives mem_wr_o.
- R4: Code 101 sets invalid_o, with all seven strobes at 0 and burst_o at 0.
- R5: For codes 100 and 110, burst_o is 1 only when both cache_ni and ken_ni were 0 at capture. Otherwise burst_o is 0.
- R6: For code 111, burst_o equals the inverse of the captured cache_ni, whatever ken_ni is.
- R7: For codes 000, 001, 010 and 011, burst_o is 0 for every value of cache_ni and ken_ni.
- R8: A clock edge with done_i at 1 and ads_ni at 1 returns every strobe, invalid_o and burst_o to 0 from that edge on.
- R9: When ads_ni is 0 and done_i is 1 at the same edge, the new cycle is captured and decoded, and the clear is dropped.
- R10: While a cycle is held, exactly one of the seven strobes and invalid_o is 1. While idle, none of them is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ads_ni | input | 1 | Address strobe, active low; marks the definition lines valid |
| mio_i | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| dc_i | input | 1 | 1 = data, 0 = code or control |
| wr_i | input | 1 | 1 = write, 0 = read |
| cache_ni | input | 1 | Processor cache request, active low |
| ken_ni | input | 1 | Cache enable returned by the system, active low |
| done_i | input | 1 | One-clock pulse ending the current cycle |
| inta_o | output | 1 | Interrupt acknowledge strobe |
| special_o | output | 1 | Special cycle strobe |
| io_rd_o | output | 1 | I/O read strobe |
| io_wr_o | output | 1 | I/O write strobe |
| fetch_o | output | 1 | Code fetch strobe |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| invalid_o | output | 1 | Reserved code seen |
| burst_o | output | 1 | 1 = four-beat burst, 0 = single transfer |

## Verification
The end of one cycle and the start of the next can land on the same edge. This happens when done_i for the held cycle coincides with a new low on ads_ni. The bench holds a memory write and then drives done_i together with a fresh address strobe carrying a burst code read. The next sample must show the fetch strobe and the burst flag, not idle and not the old write. A separate edge with done_i alone must then return all outputs to idle.

// File: rtl/cyc_pkg.sv
package cyc_pkg;
  localparam int CODE_W    = 3;
  localparam int NUM_CODES = 1 << CODE_W;

  typedef enum logic [CODE_W-1:0] {
    CYC_INTA    = 3'b000,
    CYC_SPECIAL = 3'b001,
    CYC_IO_RD   = 3'b010,
    CYC_IO_WR   = 3'b011,
    CYC_CODE_RD = 3'b100,
    CYC_RSVD    = 3'b101,
    CYC_MEM_RD  = 3'b110,
    CYC_MEM_WR  = 3'b111
  } cyc_kind_e;

  typedef struct packed {
    cyc_kind_e kind;
    logic      cache_n;
    logic      ken_n;
  } cyc_sample_t;
endpackage

// File: rtl/cyc_capture.sv
module cyc_capture
  import cyc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ads_ni,
  input  logic        done_i,
  input  cyc_sample_t sample_i,
  output logic        valid_o,
  output cyc_sample_t sample_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      sample_o <= '0;
    end else if (!ads_ni) begin
      // new cycle has priority over a coincident done
      valid_o  <= 1'b1;
      sample_o <= sample_i;
    end else if (done_i) begin
      valid_o  <= 1'b0;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ads_ni && !done_i |=> valid_o && $stable(sample_o)); // R2
endmodule

// File: rtl/cyc_classify.sv
module cyc_classify
  import cyc_pkg::*;
(
  input  logic                 valid_i,
  input  cyc_kind_e            kind_i,
  output logic [NUM_CODES-1:0] onehot_o
);
  for (genvar g = 0; g < NUM_CODES; g++) begin : g_code
    assign onehot_o[g] = valid_i && (kind_i == cyc_kind_e'(g));
  end
endmodule

// File: rtl/cyc_burst.sv
module cyc_burst
  import cyc_pkg::*;
(
  input  logic      valid_i,
  input  cyc_kind_e kind_i,
  input  logic      cache_ni,
  input  logic      ken_ni,
  output logic      burst_o
);
  always_comb begin
    burst_o = 1'b0;
    if (valid_i) begin
      unique case (kind_i)
        CYC_CODE_RD, CYC_MEM_RD: burst_o = !cache_ni && !ken_ni;
        CYC_MEM_WR:              burst_o = !cache_ni;
        default:                 burst_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/bus_cycle_decoder.sv
module bus_cycle_decoder
  import cyc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ads_ni,
  input  logic mio_i,
  input  logic dc_i,
  input  logic wr_i,
  input  logic cache_ni,
  input  logic ken_ni,
  input  logic done_i,
  output logic inta_o,
  output logic special_o,
  output logic io_rd_o,
  output logic io_wr_o,
  output logic fetch_o,
  output logic mem_rd_o,
  output logic mem_wr_o,
  output logic invalid_o,
  output logic burst_o
);
  cyc_sample_t          smp_in, smp_q;
  logic                 valid_q;
  logic [NUM_CODES-1:0] hot;

  assign smp_in.kind    = cyc_kind_e'({mio_i, dc_i, wr_i});
  assign smp_in.cache_n = cache_ni;
  assign smp_in.ken_n   = ken_ni;

  cyc_capture u_capture (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ads_ni   (ads_ni),
    .done_i   (done_i),
    .sample_i (smp_in),
    .valid_o  (valid_q),
    .sample_o (smp_q)
  );

  cyc_classify u_classify (
    .valid_i  (valid_q),
    .kind_i   (smp_q.kind),
    .onehot_o (hot)
  );

  cyc_burst u_burst (
    .valid_i  (valid_q),
    .kind_i   (smp_q.kind),
    .cache_ni (smp_q.cache_n),
    .ken_ni   (smp_q.ken_n),
    .burst_o  (burst_o)
  );

  assign inta_o    = hot[CYC_INTA];
  assign special_o = hot[CYC_SPECIAL];
  assign io_rd_o   = hot[CYC_IO_RD];
  assign io_wr_o   = hot[CYC_IO_WR];
  assign fetch_o   = hot[CYC_CODE_RD];
  assign invalid_o = hot[CYC_RSVD];
  assign mem_rd_o  = hot[CYC_MEM_RD];
  assign mem_wr_o  = hot[CYC_MEM_WR];

  logic [7:0] ind;
  assign ind = {mem_wr_o, mem_rd_o, invalid_o, fetch_o, io_wr_o, io_rd_o, special_o, inta_o};

  AST_ONE_INDICATOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ads_ni |=> $countones(ind) == 1); // R10
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ads_ni && done_i |=> ind == '0 && !burst_o); // R8
  AST_INVALID_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> !burst_o); // R4
  AST_CTRL_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_o || special_o || io_rd_o || io_wr_o) |-> !burst_o); // R7
  AST_WR_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ads_ni && mio_i && dc_i && wr_i && !cache_ni |=> mem_wr_o && burst_o); // R6
  AST_RD_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ads_ni && mio_i && !wr_i && (cache_ni || ken_ni) |=> !burst_o); // R5
endmodule

// File: tb/bus_cycle_decoder_tb.sv
module bus_cycle_decoder_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ads_n = 1'b1, mio = 1'b0, dc = 1'b0, wr = 1'b0, cache_n = 1'b1, ken_n = 1'b1, done = 1'b0;
  logic inta, special, io_rd, io_wr, fetch, mem_rd, mem_wr, invalid, burst;
  int checks = 0, failures = 0, cyc = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bus_cycle_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ads_ni(ads_n), .mio_i(mio), .dc_i(dc), .wr_i(wr),
    .cache_ni(cache_n), .ken_ni(ken_n), .done_i(done),
    .inta_o(inta), .special_o(special), .io_rd_o(io_rd), .io_wr_o(io_wr),
    .fetch_o(fetch), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .invalid_o(invalid), .burst_o(burst)
  );

  // bit c of the observed vector belongs to code c (R3); bit 5 is invalid (R4)
  function automatic logic [7:0] obs();
    return {mem_wr, mem_rd, invalid, fetch, io_wr, io_rd, special, inta};
  endfunction

  // per code: expected indicator vector and burst rule (0 never, 1 cache only, 2 cache and ken)
  localparam logic [9:0] EXP_TAB [8] = '{
    {8'b0000_0001, 2'd0}, {8'b0000_0010, 2'd0}, {8'b0000_0100, 2'd0}, {8'b0000_1000, 2'd0},
    {8'b0001_0000, 2'd2}, {8'b0010_0000, 2'd0}, {8'b0100_0000, 2'd2}, {8'b1000_0000, 2'd1}
  };

  task automatic check(string req, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic start(logic [2:0] code, logic c, logic k, logic dn);
    @(negedge clk);
    {mio, dc, wr} = code; cache_n = c; ken_n = k; ads_n = 1'b0; done = dn;
    @(negedge clk);
    ads_n = 1'b1; done = 1'b0;
    {mio, dc, wr} = ~code; cache_n = ~c; ken_n = ~k; // garbage while strobe high
  endtask

  task automatic finish_cycle();
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
  endtask

  initial begin
    while (!finished && cyc < 100000) @(posedge clk) cyc++;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset held", {obs(), burst}, 9'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {obs(), burst}, 9'b0);

    // table walk: every code with every cache/ken pair (R3 R4 R5 R6 R7 R10)
    for (int code = 0; code < 8; code++) begin
      for (int ck = 0; ck < 4; ck++) begin
        logic c, k, eb;
        c = ck[1]; k = ck[0];
        case (EXP_TAB[code][1:0])
          2'd1:    eb = !c;
          2'd2:    eb = !c && !k;
          default: eb = 1'b0;
        endcase
        start(3'(code), c, k, 1'b0);
        check($sformatf("R3 R4 R10 code=%0d ck=%0d", code, ck), {obs(), 1'b0}, {EXP_TAB[code][9:2], 1'b0});
        check($sformatf("R5 R6 R7 burst code=%0d ck=%0d", code, ck), {8'b0, burst}, {8'b0, eb});
        finish_cycle();
        check("R8 idle after done", {obs(), burst}, 9'b0);
      end
    end

    // R2: inputs moving while strobe high do nothing
    start(3'b110, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) begin
      {mio, dc, wr} = 3'(i); cache_n = i[0]; ken_n = i[1];
      @(negedge clk);
      check("R2 hold", {obs(), burst}, {8'b0100_0000, 1'b1});
    end
    finish_cycle();

    // R9: done and a new strobe on the same edge
    start(3'b111, 1'b1, 1'b1, 1'b0);
    check("R9 pre", {obs(), burst}, {8'b1000_0000, 1'b0});
    start(3'b100, 1'b0, 1'b0, 1'b1);
    check("R9 new cycle wins", {obs(), burst}, {8'b0001_0000, 1'b1});
    finish_cycle();
    check("R8 after R9", {obs(), burst}, 9'b0);

    // R1: reset in the middle of a held burst write
    start(3'b111, 1'b0, 1'b1, 1'b0);
    rst_n = 1'b0;
    #1;
    check("R1 async clear", {obs(), burst}, 9'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after release", {obs(), burst}, 9'b0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule